// File: doc/BRIEF.md
# Multiplexed-Address Byte Bus Master

This block is the host-side master of an 8-bit parallel bus. The same eight lines carry the address and the data. For each access the block takes a 16-bit address, a direction, a write byte and a target select. It then drives a fixed sequence on the bus. First the low address byte is placed on the lines and captured by its own latch strobe. The high address byte follows with a second strobe. Next the data lines are either driven with the write byte or released. After that one of two active-low chip selects falls, followed by the active-low read or write strobe.

The access ends when the target pulls its active-low acknowledge. The acknowledge passes through a two-stage synchroniser before the block uses it. If no acknowledge arrives within a parameterised number of cycles, the access ends anyway and is flagged as timed out. In both cases all four control lines rise in the same cycle. A single-cycle response then carries the sampled read byte and the timeout flag. Requests use a valid/ready handshake, and only one access is in flight at a time.

Top module: `mux_bus_master`

## Requirements
- R1: After reset and whenever no access is in progress, `cs0_n`, `cs1_n`, `rd_n` and `wr_n` are high, `adlo` and `adhi` are low, `bus_oe` is low and `req_ready` is high.
- R2: In the cycle after a request is accepted, `bus_dout` carries address bits 7:0 with `bus_oe` high and `adlo` low. `adlo` then goes high. The byte stays on the lines for one hold cycle after `adlo` falls.
- R3: Next, `bus_dout` carries address bits 15:8 for one setup cycle before `adhi` goes high, during the `adhi` pulse, and for one hold cycle after it. `adlo` and `adhi` are never high together.
- R4: Each of `adlo` and `adhi` stays high for exactly STROBE_CYC consecutive cycles per access.
- R5: In the cycle after the high-address hold, a write (`req_write`=1) drives the write byte with `bus_oe` high, and a read releases the lines (`bus_oe` low). This state holds until the access ends.
- R6: One cycle after the data phase, the selected chip select falls (`req_sel`=0 selects `cs0_n`, 1 selects `cs1_n`). One cycle later, `rd_n` (read) or `wr_n` (write) falls. A strobe is never low without a chip select low.
- R7: `ack_n` is used only after two register stages. The first cycle in which the synchronised acknowledge is low ends the access. For a read, `rsp_rdata` is the byte on `bus_din` at that clock edge; for a write it is zero.
- R8: If the synchronised acknowledge stays high for TIMEOUT_CYC cycles of the strobe-low phase, the access ends with `rsp_timeout`=1 and `rsp_rdata`=0.
- R9: When an access ends, `cs0_n`, `cs1_n`, `rd_n` and `wr_n` all return high in the same cycle, `bus_oe` drops, and `rsp_valid` is high for exactly that one cycle.
- R10: `req_ready` is high only when the block is idle, so a request held valid during an access is not taken. `busy` stays high from acceptance through the cycle in which the controls are back at idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_sel | input | 1 | Target select: 0 first device, 1 second device |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read (zero for writes and timeouts) |
| rsp_timeout | output | 1 | Access ended without acknowledge |
| busy | output | 1 | Access in progress |
| bus_dout | output | 8 | Byte driven onto the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| bus_din | input | 8 | Byte sampled from the shared lines |
| adlo | output | 1 | Low address latch strobe, active high |
| adhi | output | 1 | High address latch strobe, active high |
| cs0_n | output | 1 | Chip select of the first device |
| cs1_n | output | 1 | Chip select of the second device |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| ack_n | input | 1 | Acknowledge from the target, asynchronous |

## Verification
The bench changes `bus_din` on every cycle, so a master that samples the read byte one cycle early or late, or that skips a synchroniser stage, returns a different value than expected. Acknowledge delays are placed just before, at and just past the timeout limit. This exposes an off-by-one in the wait counter, which would flip `rsp_timeout` or move the end of the access by a cycle. A request stream that holds `req_valid` high while fields change every cycle checks two failure modes. A master that accepts during an access would launch a second address phase. A master that latches the fields late would put the wrong bytes on the lines.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    // Access sequencer states; the order follows the bus sequence
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LO_SU,
        ST_LO_STB,
        ST_LO_HLD,
        ST_HI_SU,
        ST_HI_STB,
        ST_HI_HLD,
        ST_DATA,
        ST_SEL,
        ST_WAIT,
        ST_DONE
    } mbm_state_e;

endpackage

// File: rtl/mbm_ack_sync.sv
module mbm_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] sh_q;

    // Resets to the inactive (high) level of the acknowledge line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = sh_q[STAGES-1];

endmodule

// File: rtl/mbm_wait_timer.sv
module mbm_wait_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // High in the LIMIT-th cycle of a run
    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
    import mbm_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int STROBE_CYC  = 2,
    parameter int TIMEOUT_CYC = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [2*BYTE_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              req_sel,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_rdata,
    output logic              rsp_timeout,
    output logic              busy,
    output logic [BYTE_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [BYTE_W-1:0] bus_din,
    output logic              adlo,
    output logic              adhi,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic              rd_n,
    output logic              wr_n,
    input  logic              ack_n
);

    localparam int ADDR_W = 2 * BYTE_W;
    localparam int CW     = $clog2(STROBE_CYC + 1);
    localparam logic [CW-1:0] STB_LAST = CW'(STROBE_CYC - 1);

    typedef struct packed {
        mbm_state_e        state;
        logic [CW-1:0]     stb_cnt;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic              write;
        logic              sel;
        logic [BYTE_W-1:0] dout;
        logic              oe;
        logic              adlo;
        logic              adhi;
        logic              cs0_n;
        logic              cs1_n;
        logic              rd_n;
        logic              wr_n;
        logic [BYTE_W-1:0] rdata;
        logic              tmo;
    } mbm_regs_t;

    localparam mbm_regs_t REGS_RST = '{
        state:   ST_IDLE,
        stb_cnt: '0,
        addr:    '0,
        wdata:   '0,
        write:   1'b0,
        sel:     1'b0,
        dout:    '0,
        oe:      1'b0,
        adlo:    1'b0,
        adhi:    1'b0,
        cs0_n:   1'b1,
        cs1_n:   1'b1,
        rd_n:    1'b1,
        wr_n:    1'b1,
        rdata:   '0,
        tmo:     1'b0
    };

    mbm_regs_t r_q, r_d;
    logic      ack_sync;
    logic      wait_expired;

    mbm_ack_sync #(
        .STAGES (SYNC_STAGES)
    ) u_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ack_n),
        .sync_out (ack_sync)
    );

    mbm_wait_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_wait_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.state == ST_WAIT),
        .expired (wait_expired)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.write = req_write;
                    r_d.sel   = req_sel;
                    r_d.dout  = req_addr[BYTE_W-1:0];
                    r_d.oe    = 1'b1;
                    r_d.rdata = '0;
                    r_d.tmo   = 1'b0;
                    r_d.state = ST_LO_SU;
                end
            end
            ST_LO_SU: begin
                r_d.adlo    = 1'b1;
                r_d.stb_cnt = STB_LAST;
                r_d.state   = ST_LO_STB;
            end
            ST_LO_STB: begin
                if (r_q.stb_cnt == '0) begin
                    r_d.adlo  = 1'b0;
                    r_d.state = ST_LO_HLD;
                end else begin
                    r_d.stb_cnt = r_q.stb_cnt - 1'b1;
                end
            end
            ST_LO_HLD: begin
                r_d.dout  = r_q.addr[ADDR_W-1:BYTE_W];
                r_d.state = ST_HI_SU;
            end
            ST_HI_SU: begin
                r_d.adhi    = 1'b1;
                r_d.stb_cnt = STB_LAST;
                r_d.state   = ST_HI_STB;
            end
            ST_HI_STB: begin
                if (r_q.stb_cnt == '0) begin
                    r_d.adhi  = 1'b0;
                    r_d.state = ST_HI_HLD;
                end else begin
                    r_d.stb_cnt = r_q.stb_cnt - 1'b1;
                end
            end
            ST_HI_HLD: begin
                r_d.dout  = r_q.write ? r_q.wdata : '0;
                r_d.oe    = r_q.write;
                r_d.state = ST_DATA;
            end
            ST_DATA: begin
                r_d.cs0_n = r_q.sel;
                r_d.cs1_n = !r_q.sel;
                r_d.state = ST_SEL;
            end
            ST_SEL: begin
                r_d.rd_n  = r_q.write;
                r_d.wr_n  = !r_q.write;
                r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (!ack_sync || wait_expired) begin
                    r_d.cs0_n = 1'b1;
                    r_d.cs1_n = 1'b1;
                    r_d.rd_n  = 1'b1;
                    r_d.wr_n  = 1'b1;
                    r_d.oe    = 1'b0;
                    r_d.state = ST_DONE;
                    if (!ack_sync) begin
                        r_d.rdata = r_q.write ? '0 : bus_din;
                        r_d.tmo   = 1'b0;
                    end else begin
                        r_d.rdata = '0;
                        r_d.tmo   = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d = REGS_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.state == ST_IDLE);
    assign busy        = (r_q.state != ST_IDLE);
    assign rsp_valid   = (r_q.state == ST_DONE);
    assign rsp_rdata   = r_q.rdata;
    assign rsp_timeout = r_q.tmo;
    assign bus_dout    = r_q.dout;
    assign bus_oe      = r_q.oe;
    assign adlo        = r_q.adlo;
    assign adhi        = r_q.adhi;
    assign cs0_n       = r_q.cs0_n;
    assign cs1_n       = r_q.cs1_n;
    assign rd_n        = r_q.rd_n;
    assign wr_n        = r_q.wr_n;

endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
    parameter int STROBE_CYC  = 2,
    parameter int TIMEOUT_CYC = 50000
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_valid,
    input logic busy,
    input logic bus_oe,
    input logic adlo,
    input logic adhi,
    input logic cs0_n,
    input logic cs1_n,
    input logic rd_n,
    input logic wr_n
);

    logic [31:0] lo_run_q, hi_run_q, wait_run_q;
    logic        strobe_low;

    assign strobe_low = !rd_n || !wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run_q   <= '0;
            hi_run_q   <= '0;
            wait_run_q <= '0;
        end else begin
            lo_run_q   <= adlo ? lo_run_q + 32'd1 : '0;
            hi_run_q   <= adhi ? hi_run_q + 32'd1 : '0;
            wait_run_q <= strobe_low ? wait_run_q + 32'd1 : '0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs0_n && cs1_n && rd_n && wr_n && !adlo && !adhi && !bus_oe));

    p_latch_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adlo || adhi) |-> bus_oe);

    p_latch_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(adlo && adhi));

    p_lo_width_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adlo |-> (lo_run_q < STROBE_CYC));

    p_lo_width_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adlo) |-> (lo_run_q == STROBE_CYC));

    p_hi_width_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adhi) |-> (hi_run_q == STROBE_CYC));

    p_read_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);

    p_strobe_under_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low |-> (!cs0_n || !cs1_n));

    p_single_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs0_n && !cs1_n) && !(!rd_n && !wr_n));

    p_wait_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low |-> (wait_run_q < TIMEOUT_CYC));

    p_release_together_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (cs0_n && cs1_n && rd_n && wr_n && !bus_oe));

    p_resp_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !busy);

endmodule

bind mux_bus_master mbm_checker #(
    .STROBE_CYC  (STROBE_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_mbm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .bus_oe    (bus_oe),
    .adlo      (adlo),
    .adhi      (adhi),
    .cs0_n     (cs0_n),
    .cs1_n     (cs1_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/mux_bus_master_tb.sv
module mux_bus_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int STB = 2;
    localparam int TMO = 20;
    localparam int W   = 2 * STB + 6;   // cycle index of the strobe-low phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_sel = 1'b0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        rsp_timeout;
    logic        busy;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic [7:0]  bus_din = '0;
    logic        adlo, adhi, cs0_n, cs1_n, rd_n, wr_n;
    logic        ack_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    mux_bus_master #(
        .STROBE_CYC  (STB),
        .TIMEOUT_CYC (TMO)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_sel (req_sel),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .rsp_timeout (rsp_timeout),
        .busy (busy), .bus_dout (bus_dout), .bus_oe (bus_oe), .bus_din (bus_din),
        .adlo (adlo), .adhi (adhi), .cs0_n (cs0_n), .cs1_n (cs1_n),
        .rd_n (rd_n), .wr_n (wr_n), .ack_n (ack_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, name, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit        mb = 0;       // access in progress
    bit        md = 0;       // completion cycle
    int        s  = 0;       // cycles since acceptance
    bit        m1 = 1, m2 = 1;
    bit [15:0] ma;
    bit [7:0]  mwd;
    bit        mw, ms;
    int        e_rdata = 0;
    bit        e_tmo = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mb = 0; md = 0; s = 0; m1 = 1; m2 = 1;
        end else begin
            bit a2;
            a2 = m2; m2 = m1; m1 = ack_n;
            if (!mb) begin
                if (req_valid) begin
                    mb = 1; md = 0; s = 0;
                    ma = req_addr; mwd = req_wdata; mw = req_write; ms = req_sel;
                end
            end else if (md) begin
                mb = 0; md = 0;
            end else if (s >= W) begin
                if (!a2) begin
                    md = 1; e_tmo = 0; e_rdata = mw ? 0 : int'(bus_din);
                end else if (s - W == TMO - 1) begin
                    md = 1; e_tmo = 1; e_rdata = 0;
                end else begin
                    s++;
                end
            end else begin
                s++;
            end
        end
    end

    // ---------------- comparison, away from the clock edge ----------------
    always @(negedge clk) begin
        if (!finished) begin
            if (!mb) begin
                chk("R1", "cs0_n", cs0_n, 1); chk("R1", "cs1_n", cs1_n, 1);
                chk("R1", "rd_n", rd_n, 1);   chk("R1", "wr_n", wr_n, 1);
                chk("R1", "adlo", adlo, 0);   chk("R1", "adhi", adhi, 0);
                chk("R1", "bus_oe", bus_oe, 0);
                chk("R10", "req_ready", req_ready, 1); chk("R10", "busy", busy, 0);
                chk("R9", "rsp_valid", rsp_valid, 0);
            end else if (md) begin
                chk("R9", "cs0_n", cs0_n, 1); chk("R9", "cs1_n", cs1_n, 1);
                chk("R9", "rd_n", rd_n, 1);   chk("R9", "wr_n", wr_n, 1);
                chk("R9", "bus_oe", bus_oe, 0);
                chk("R9", "rsp_valid", rsp_valid, 1);
                chk("R8", "rsp_timeout", rsp_timeout, int'(e_tmo));
                chk("R7", "rsp_rdata", rsp_rdata, e_rdata);
                chk("R10", "busy", busy, 1); chk("R10", "req_ready", req_ready, 0);
            end else begin
                chk("R10", "busy", busy, 1); chk("R10", "req_ready", req_ready, 0);
                chk("R9", "rsp_valid", rsp_valid, 0);
                chk("R4", "adlo", adlo, int'(s >= 1 && s <= STB));
                chk("R4", "adhi", adhi, int'(s >= STB + 3 && s <= 2 * STB + 2));
                if (s <= STB + 1) begin
                    chk("R2", "bus_oe", bus_oe, 1);
                    chk("R2", "bus_dout", bus_dout, int'(ma[7:0]));
                end else if (s <= 2 * STB + 3) begin
                    chk("R3", "bus_oe", bus_oe, 1);
                    chk("R3", "bus_dout", bus_dout, int'(ma[15:8]));
                end else begin
                    chk("R5", "bus_oe", bus_oe, int'(mw));
                    if (mw) chk("R5", "bus_dout", bus_dout, int'(mwd));
                end
                chk("R6", "cs0_n", cs0_n, int'(!(s >= 2 * STB + 5 && !ms)));
                chk("R6", "cs1_n", cs1_n, int'(!(s >= 2 * STB + 5 && ms)));
                chk("R6", "rd_n", rd_n, int'(!(s >= W && !mw)));
                chk("R6", "wr_n", wr_n, int'(!(s >= W && mw)));
            end
        end
    end

    // ---------------- target device and changing read lines ----------------
    int ack_delay = 0;   // negative: never acknowledge
    int strobe_cnt = 0;
    always @(negedge clk) begin
        bus_din <= bus_din + 8'd37;
        if (!rd_n || !wr_n) begin
            strobe_cnt = strobe_cnt + 1;
            if (ack_delay >= 0 && strobe_cnt > ack_delay) ack_n <= 1'b0;
        end else begin
            strobe_cnt = 0;
            ack_n <= 1'b1;
        end
    end

    task automatic one_access(input bit wr, input bit [15:0] a, input bit [7:0] d,
                              input bit sel, input int dly);
        @(negedge clk);
        ack_delay = dly;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_sel = sel;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state is compared every idle cycle; R2..R9 in each access
        one_access(1'b1, 16'hA55A, 8'h3C, 1'b0, 3);     // write, first device
        one_access(1'b0, 16'h1234, 8'h00, 1'b1, 0);     // read, second device
        one_access(1'b0, 16'hFF00, 8'h00, 1'b0, -1);    // R8 read timeout
        one_access(1'b1, 16'h00FF, 8'hC3, 1'b1, -1);    // R8 write timeout
        one_access(1'b0, 16'h8001, 8'h00, 1'b1, 16);    // R8 boundary, just in time
        one_access(1'b0, 16'h7FFE, 8'h00, 1'b0, 17);    // R8 boundary
        one_access(1'b1, 16'h4321, 8'h99, 1'b0, 18);    // R8 boundary, too late
        // R10: valid held through accesses while fields change each cycle
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            req_valid = (i % 7) != 3;
            req_write = i[1];
            req_sel   = i[2];
            req_addr  = 16'(i * 16'h1357 + 16'h0101);
            req_wdata = 8'(i * 11);
            if (i % 40 == 0) ack_delay = (i / 40) % 5 == 4 ? -1 : (i / 40) % 5 * 3;
        end
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule